// File: doc/BRIEF.md
# CRC32 Byte Accumulator

This block keeps a running 32-bit cyclic redundancy check over a stream of bytes that a transfer engine delivers, one byte on each cycle where the valid input is high. Software first applies a load strobe that captures both the generator polynomial and the starting register value. After that, each valid byte updates the register in a single clock cycle.

A mode code can reverse the bit order of each incoming byte before it enters the register. This lets the same datapath serve both reflected-input and plain-input checksum conventions. The block returns the register exactly as it stands. Any final inversion or reflection of the output is left to the consumer.

Top module: `crc32_byte_acc`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `crc_out` is 0x00000000.
- R2: A cycle with `load` high makes `crc_out` equal `init_in` from the following cycle. The same edge captures `poly_in` as the polynomial used for later bytes.
- R3: When `load` and `in_valid` are high in the same cycle, the load wins and the byte is discarded. On the next cycle `crc_out` equals `init_in`.
- R4: Each cycle with `in_valid` high and `load` low absorbs `in_byte` MSB first into a left-shifting register. For each bit, the feedback is the register's top bit XOR the data bit; the register shifts left and is XORed with the polynomial when the feedback is 1. The new value appears on `crc_out` on the next cycle.
- R5: Bit 0 of the captured polynomial is always treated as 1. A polynomial of 0x04C11DB6 gives the same results as 0x04C11DB7.
- R6: With `mode` equal to 1, each byte is bit-reversed before use (0x47 is used as 0xE2). With polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, the ASCII string "123456789" yields 0x9B63D02C.
- R7: Any `mode` value other than 1 (0, 2 to 15) uses the byte unchanged. With polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, "123456789" yields 0x0376E6E7.
- R8: No final XOR and no output bit reversal are applied: `crc_out` is the raw register value.
- R9: While `load` and `in_valid` are both low, `crc_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture polynomial and initial value |
| poly_in | input | 32 | Generator polynomial (bit 0 forced to 1) |
| init_in | input | 32 | Starting register value |
| mode | input | 4 | Input byte order code; 1 means reverse bits |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Data byte |
| crc_out | output | 32 | Raw shift register contents |

## Verification
The nine-byte ASCII check string is run under mode 0, under mode 1 and under the unused codes 2, 7 and 15. Comparing these results against the two known register values separates plain input from reflected input, and shows whether a final XOR or an output reflection has slipped in. Running it again with a polynomial whose bit 0 is clear detects a missing forced constant term. Random bytes with idle gaps and mixed modes are compared against a data-first reference on every clock, which exposes wrong bit order, wrong feedback and missing hold behaviour. A load that arrives together with a valid byte shows which of the two takes priority.

// File: rtl/crc32_byte_acc.sv
module crc32_byte_acc #(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CRC_W-1:0]  poly_in,
  input  logic [CRC_W-1:0]  init_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [CRC_W-1:0]  crc_out
);

  localparam logic [MODE_W-1:0] MODE_REFLECT = MODE_W'(1);

  logic [CRC_W-1:0]  crc_q, poly_q;
  logic [BYTE_W-1:0] byte_rev, byte_use;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign byte_rev[i] = in_byte[BYTE_W-1-i];
  end

  assign byte_use = (mode == MODE_REFLECT) ? byte_rev : in_byte;

  function automatic logic [CRC_W-1:0] absorb(input logic [CRC_W-1:0] c_in,
                                              input logic [CRC_W-1:0] p,
                                              input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '0;
      poly_q <= CRC_W'(1);
    end else if (load) begin
      crc_q  <= init_in;
      poly_q <= poly_in | CRC_W'(1);
    end else if (in_valid) begin
      crc_q  <= absorb(crc_q, poly_q, byte_use);
    end
  end

  assign crc_out = crc_q;

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> crc_out == $past(init_in)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid) |=> crc_out == $past(init_in)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !in_valid) |=> $stable(crc_out)); // R9

  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && in_valid && crc_out == '0 && byte_use == '0) |=> crc_out == '0); // R4

  AST_POLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && in_valid && crc_out == '0 && byte_use == BYTE_W'(1))
      |=> crc_out[0]); // R5

endmodule

// File: tb/crc32_byte_acc_test.sv
`timescale 1ns/1ps
module crc32_byte_acc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic [31:0] poly_in = '0, init_in = '0;
  logic [3:0]  mode = '0;
  logic        in_valid = 0;
  logic [7:0]  in_byte = '0;
  logic [31:0] crc_out;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crc32_byte_acc uut (.clk(clk), .rst_n(rst_n), .load(load), .poly_in(poly_in),
    .init_in(init_in), .mode(mode), .in_valid(in_valid), .in_byte(in_byte),
    .crc_out(crc_out));

  // behavioural reference: data XORed into the top byte first, then 8 shifts
  logic [31:0] m_crc, m_poly;
  function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] p, logic [7:0] b);
    logic [31:0] r = c ^ {b, 24'h0};
    repeat (8) r = r[31] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_crc <= 32'h0; m_poly <= 32'h1; end
    else if (load) begin m_crc <= init_in; m_poly <= {poly_in[31:1], 1'b1}; end
    else if (in_valid) m_crc <= ref_step(m_crc, m_poly, (mode == 4'd1) ? {<<{in_byte}} : in_byte);
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-clock comparison against the reference (R4, R9)
  always @(negedge clk) if (rst_n && !done) chk("R4", crc_out, m_crc);

  task automatic do_load(logic [31:0] p, logic [31:0] i);
    @(negedge clk); load = 1; poly_in = p; init_in = i; in_valid = 0;
    @(negedge clk); load = 0;
  endtask

  task automatic feed(logic [7:0] b);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic run_check(logic [31:0] p, logic [3:0] md);
    do_load(p, 32'hFFFF_FFFF);
    mode = md;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); in_valid = 1; in_byte = 8'h31 + 8'(k);
    end
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++; checks++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [31:0] hold_v;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1", crc_out, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", crc_out, 32'h0);

    do_load(32'h04C1_1DB7, 32'h1234_5678);
    chk("R2", crc_out, 32'h1234_5678);

    run_check(32'h04C1_1DB7, 4'd0);
    chk("R7", crc_out, 32'h0376_E6E7);
    chk("R8", crc_out, 32'h0376_E6E7);
    hold_v = crc_out;
    repeat (5) @(negedge clk);
    chk("R9", crc_out, hold_v);

    run_check(32'h04C1_1DB6, 4'd0);
    chk("R5", crc_out, 32'h0376_E6E7);

    run_check(32'h04C1_1DB7, 4'd1);
    chk("R6", crc_out, 32'h9B63_D02C);
    chk("R8", crc_out, 32'h9B63_D02C);

    run_check(32'h04C1_1DB7, 4'd2);  chk("R7", crc_out, 32'h0376_E6E7);
    run_check(32'h04C1_1DB7, 4'd7);  chk("R7", crc_out, 32'h0376_E6E7);
    run_check(32'h04C1_1DB7, 4'd15); chk("R7", crc_out, 32'h0376_E6E7);

    // R6: 0x47 reflected equals 0xE2 plain
    do_load(32'h04C1_1DB7, 32'h0);
    mode = 4'd0; feed(8'hE2); hold_v = crc_out;
    do_load(32'h04C1_1DB7, 32'h0);
    mode = 4'd1; feed(8'h47);
    chk("R6", crc_out, hold_v);

    // R3: load and valid together
    @(negedge clk); load = 1; in_valid = 1; in_byte = 8'hA5;
    poly_in = 32'h1EDC_6F41; init_in = 32'hCAFE_F00D;
    @(negedge clk); load = 0; in_valid = 0;
    chk("R3", crc_out, 32'hCAFE_F00D);

    // R4: random bytes, gaps and modes, compared every clock
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      in_byte  = 8'($urandom);
      mode     = 4'($urandom);
      load     = ($urandom_range(0, 60) == 0);
      poly_in  = $urandom;
      init_in  = $urandom;
    end
    @(negedge clk); load = 0; in_valid = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule